// File: doc/BRIEF.md
# Recurring-Decimal Reciprocal Digit Generator

This block produces the decimal expansion of a reciprocal one digit at a time. It does this without dividing by the full multi-digit number. An upstream stage first turns the number into a small working divisor by rounding it to the next multiple of ten and dropping the trailing zero. That stage also picks a feedback rule that makes up for the rounding. The generator then runs a chain of short divisions. Each partial dividend is ten times the previous remainder plus a small function of the previous quotient digit. Each quotient digit is one decimal digit of the reciprocal.

A run starts with a one-cycle `start` pulse while the block is idle. On that pulse the block captures the working divisor, the starting remainder and the feedback rule. The first digit is the starting remainder divided by the divisor, which is normally a leading zero. Sixteen BCD digits follow, each with a one-cycle strobe, and `done` pulses once the run is over. Scaling by a power of ten and formatting of the result are left to the surrounding logic.

Each digit comes from a restoring loop. Every cycle the loop subtracts the divisor from the partial dividend while the partial dividend is at least the divisor and fewer than nine subtractions have been made. A digit therefore takes one to ten cycles.

Top module: `recip_digit_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `digit_valid` and `done` are low.
- R2: A `start` pulse seen while `busy` is low captures `divisor`, `init_rem` and `fb_sel`, and `busy` is high in the following cycle.
- R3: The first digit emitted in a run is floor(`init_rem` / `divisor`), so a starting remainder below the divisor yields a leading 0.
- R4: Every later digit is floor(P / `divisor`). Here P = 10·r + f(q), where r is the remainder and q the digit of the previous step. The term f(q) is q for `fb_sel`=00, 2q for 01, 3q for 10, and 9−q for 11.
- R5: `digit` is a 4-bit BCD value in the range 0 to 9 whenever `digit_valid` is high, and each high cycle of `digit_valid` delivers exactly one digit.
- R6: A run emits exactly 16 digits.
- R7: `done` is high for exactly one cycle, in the cycle right after the 16th digit strobe, and `busy` is low in that cycle.
- R8: A `start` pulse while `busy` is high is ignored: the digit stream in progress, and the operands it was computed from, do not change.
- R9: No more than ten cycles pass between an accepted start or a digit strobe and the following digit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| divisor | input | 10 | Working divisor, binary, 1 to 999 |
| init_rem | input | 10 | Starting remainder, binary |
| fb_sel | input | 2 | Feedback rule: 00 q, 01 2q, 10 3q, 11 9−q |
| busy | output | 1 | Run in progress |
| digit_valid | output | 1 | One-cycle strobe for `digit` |
| digit | output | 4 | Current BCD digit |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions assume a few things about the inputs. `divisor` must be nonzero, and `start` must be a clean synchronous pulse. Timing and counting properties hold for any operands because the subtract loop is capped at nine. Correct digit values additionally need every partial dividend to stay below ten times the divisor. That always holds for the q and 9−q rules, but not always for the 2q and 3q rules.

The stimulus uses working divisors derived from numbers ending in 9, 1, 8 and 7. It compares the emitted digits with the true decimal expansion of the original number. For the 3q case, only the digits produced before a partial dividend reaches ten times the divisor are compared. One run adds a start pulse with different operands in the middle of the run.

// File: rtl/recip_pkg.sv
package recip_pkg;

    // Feedback rule applied to the previous quotient digit.
    typedef enum logic [1:0] {
        FB_ADD_Q        = 2'b00,
        FB_ADD_2Q       = 2'b01,
        FB_ADD_3Q       = 2'b10,
        FB_NINE_MINUS_Q = 2'b11
    } fb_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    localparam logic [3:0] DIGIT_TOP = 4'd9;
    localparam int         FB_W      = 5;   // max term 27

    function automatic logic [FB_W-1:0] fb_value(fb_sel_e sel, logic [3:0] q);
        logic [FB_W-1:0] qx;
        qx = {1'b0, q};
        case (sel)
            FB_ADD_Q:  fb_value = qx;
            FB_ADD_2Q: fb_value = qx << 1;
            FB_ADD_3Q: fb_value = (qx << 1) + qx;
            default:   fb_value = 5'd9 - qx;
        endcase
    endfunction

endpackage

// File: rtl/recip_step.sv
// Combinational datapath of one loop iteration: the subtract decision,
// the reduced partial dividend, and the next digit's partial dividend.
module recip_step
    import recip_pkg::*;
#(
    parameter int D_W = 10,
    parameter int R_W = 14
) (
    input  logic [R_W-1:0] part,
    input  logic [D_W-1:0] dvs,
    input  logic [3:0]     qcnt,
    input  fb_sel_e        sel,
    output logic           can_sub,
    output logic [R_W-1:0] part_sub,
    output logic [R_W-1:0] part_next
);
    localparam int PAD   = R_W - D_W;
    localparam int FBPAD = R_W - FB_W;

    logic [R_W-1:0] dvs_x;
    logic [R_W-1:0] fb_x;

    assign dvs_x = {{PAD{1'b0}}, dvs};
    assign fb_x  = {{FBPAD{1'b0}}, fb_value(sel, qcnt)};

    // Subtract only while the divisor still fits and the digit is below 9.
    assign can_sub  = (part >= dvs_x) && (qcnt != DIGIT_TOP);
    assign part_sub = part - dvs_x;

    // Remainder times ten, plus the feedback term of the digit just found.
    assign part_next = (part << 3) + (part << 1) + fb_x;

endmodule

// File: rtl/recip_seq.sv
// Run control: operand capture, per-digit subtract loop and digit counting.
module recip_seq
    import recip_pkg::*;
#(
    parameter int N_DIGITS = 16,
    parameter int D_W      = 10,
    parameter int R_W      = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [D_W-1:0] divisor,
    input  logic [D_W-1:0] init_rem,
    input  fb_sel_e        fb_sel,
    input  logic           can_sub,
    input  logic [R_W-1:0] part_sub,
    input  logic [R_W-1:0] part_next,
    output logic [R_W-1:0] part,
    output logic [3:0]     qcnt,
    output logic [D_W-1:0] dvs_q,
    output fb_sel_e        sel_q,
    output logic           busy,
    output logic           digit_valid,
    output logic [3:0]     digit,
    output logic           done
);
    localparam int             IDX_W = (N_DIGITS > 1) ? $clog2(N_DIGITS) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_DIGITS - 1);
    localparam int             PAD   = R_W - D_W;

    seq_state_e       st;
    logic [IDX_W-1:0] idx;

    assign busy = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            part        <= '0;
            qcnt        <= '0;
            idx         <= '0;
            dvs_q       <= '0;
            sel_q       <= FB_ADD_Q;
            digit_valid <= 1'b0;
            digit       <= '0;
            done        <= 1'b0;
        end else begin
            digit_valid <= 1'b0;
            done        <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        dvs_q <= divisor;
                        sel_q <= fb_sel;
                        part  <= {{PAD{1'b0}}, init_rem};
                        qcnt  <= '0;
                        idx   <= '0;
                        st    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (can_sub) begin
                        part <= part_sub;
                        qcnt <= qcnt + 4'd1;
                    end else begin
                        digit_valid <= 1'b1;
                        digit       <= qcnt;
                        part        <= part_next;
                        qcnt        <= '0;
                        idx         <= idx + 1'b1;
                        if (idx == LAST) st <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/recip_digit_gen.sv
module recip_digit_gen
    import recip_pkg::*;
#(
    parameter int D_MAX    = 999,
    parameter int N_DIGITS = 16,
    localparam int D_W     = $clog2(D_MAX + 1),
    localparam int R_W     = $clog2(10 * D_MAX + 28)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [D_W-1:0] divisor,
    input  logic [D_W-1:0] init_rem,
    input  logic [1:0]     fb_sel,
    output logic           busy,
    output logic           digit_valid,
    output logic [3:0]     digit,
    output logic           done
);
    fb_sel_e        sel_in;
    fb_sel_e        sel_q;
    logic [R_W-1:0] part;
    logic [R_W-1:0] part_sub;
    logic [R_W-1:0] part_next;
    logic [3:0]     qcnt;
    logic [D_W-1:0] dvs_q;
    logic           can_sub;

    assign sel_in = fb_sel_e'(fb_sel);

    recip_step #(.D_W(D_W), .R_W(R_W)) u_step (
        .part      (part),
        .dvs       (dvs_q),
        .qcnt      (qcnt),
        .sel       (sel_q),
        .can_sub   (can_sub),
        .part_sub  (part_sub),
        .part_next (part_next)
    );

    recip_seq #(.N_DIGITS(N_DIGITS), .D_W(D_W), .R_W(R_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .divisor     (divisor),
        .init_rem    (init_rem),
        .fb_sel      (sel_in),
        .can_sub     (can_sub),
        .part_sub    (part_sub),
        .part_next   (part_next),
        .part        (part),
        .qcnt        (qcnt),
        .dvs_q       (dvs_q),
        .sel_q       (sel_q),
        .busy        (busy),
        .digit_valid (digit_valid),
        .digit       (digit),
        .done        (done)
    );

endmodule

// File: rtl/recip_digit_gen_chk.sv
module recip_digit_gen_chk #(
    parameter int N_DIGITS = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       digit_valid,
    input logic [3:0] digit,
    input logic       done
);
    localparam int CW = $clog2(N_DIGITS + 1) + 1;

    logic [CW-1:0] dig_cnt;
    logic [4:0]    gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            dig_cnt <= '0;
            gap     <= '0;
        end else begin
            if (start && !busy)   dig_cnt <= '0;
            else if (digit_valid) dig_cnt <= dig_cnt + 1'b1;

            if ((start && !busy) || digit_valid) gap <= '0;
            else if (busy && gap != 5'd31)        gap <= gap + 5'd1;
        end
    end

    a_r2_busy_follows_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    a_r5_digit_bcd: assert property (@(posedge clk) disable iff (rst)
        digit_valid |-> (digit <= 4'd9));

    a_r5_strobe_in_run: assert property (@(posedge clk) disable iff (rst)
        digit_valid |-> busy);

    a_r6_digit_count: assert property (@(posedge clk) disable iff (rst)
        done |-> (dig_cnt == CW'(N_DIGITS)));

    a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(digit_valid));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r9_digit_gap: assert property (@(posedge clk) disable iff (rst)
        busy |-> (gap <= 5'd10));

endmodule

bind recip_digit_gen recip_digit_gen_chk #(.N_DIGITS(N_DIGITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .digit_valid (digit_valid),
    .digit       (digit),
    .done        (done)
);

// File: tb/recip_digit_gen_bench.sv
module recip_digit_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [9:0] divisor;
    logic [9:0] init_rem;
    logic [1:0] fb_sel;
    logic       busy;
    logic       digit_valid;
    logic [3:0] digit;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    recip_digit_gen u_recip_digit_gen (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .divisor     (divisor),
        .init_rem    (init_rem),
        .fb_sel      (fb_sel),
        .busy        (busy),
        .digit_valid (digit_valid),
        .digit       (digit),
        .done        (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; divisor = '0; init_rem = '0; fb_sel = 2'b00;
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(digit_valid == 1'b0, "R1", "digit_valid in reset", digit_valid, 0);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && digit_valid == 1'b0,
              "R1", "outputs after reset", int'({busy, done, digit_valid}), 0);
    endtask

    // exp holds the expected digits as BCD nibbles, first digit in the top nibble.
    task automatic run_case(input string name, input int dv, input int init,
                            input logic [1:0] sel, input logic [63:0] exp,
                            input int nchk, input bit poke);
        int  cnt = 0;
        int  gap = 1;
        int  cyc = 0;
        bit  prev_dv = 1'b0;
        bit  poked = 1'b0;
        bit  fin = 1'b0;
        $display("case %s", name);
        @(negedge clk);
        divisor = 10'(dv); init_rem = 10'(init); fb_sel = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", busy, 1);
        while (!fin) begin
            if (poked) start = 1'b0;
            if (digit_valid) begin
                if (cnt < nchk) begin
                    if (cnt == 0)
                        check(digit == exp[63 -: 4], "R3", "leading digit",
                              digit, exp[63 -: 4]);
                    else
                        check(digit == exp[63-4*cnt -: 4], "R4", "digit value",
                              digit, exp[63-4*cnt -: 4]);
                end
                check(digit <= 4'd9, "R5", "digit is BCD", digit, 9);
                check(gap <= ((cnt == 0) ? 11 : 10), "R9", "cycles between digits",
                      gap, 10);
                gap = 0;
                cnt++;
            end
            if (done) begin
                check(prev_dv, "R7", "done right after last digit", prev_dv, 1);
                check(cnt == 16, "R6", "digit count", cnt, 16);
                check(busy == 1'b0, "R7", "busy low with done", busy, 0);
                fin = 1'b1;
            end
            if (poke && !poked && cnt == 3) begin
                // R8: start with other operands in the middle of a run
                divisor = 10'd7; init_rem = 10'd3; fb_sel = 2'b11; start = 1'b1;
                poked = 1'b1;
            end
            prev_dv = digit_valid;
            if (!fin) begin
                if (cyc > 400) begin
                    check(1'b0, "R6", "run never finished", cnt, 16);
                    fin = 1'b1;
                end
                @(negedge clk);
                gap++;
                cyc++;
            end
        end
        if (poke) check(poked, "R8", "start pulse issued mid-run", poked, 1);
        start = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R7", "done lasts one cycle", done, 0);
        check(busy == 1'b0, "R8", "no restart from ignored start", busy, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R6 actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        // 1/59: divisor 6, remainder 1, feedback q
        run_case("R4 q rule 1/59", 6, 1, 2'b00, 64'h0169491525423728, 16, 1'b0);
        // 1/61: divisor 6, remainder 0, feedback 9-q
        run_case("R4 nine-minus rule 1/61", 6, 0, 2'b11, 64'h0163934426229508, 16, 1'b0);
        // 1/388: divisor 39, feedback 2q
        run_case("R4 2q rule 1/388", 39, 1, 2'b01, 64'h0025773195876288, 16, 1'b0);
        // 1/789: divisor 79, three-digit number, feedback q
        run_case("R4 q rule 1/789", 79, 1, 2'b00, 64'h0012674271229404, 16, 1'b0);
        // 1/97: divisor 10, feedback 3q, compare the ten digits before the bound is exceeded
        run_case("R4 3q rule 1/97", 10, 1, 2'b10, 64'h0103092783000000, 10, 1'b0);
        // R8: repeat 1/59 with a start pulse during the run
        run_case("R8 ignored start 1/59", 6, 1, 2'b00, 64'h0169491525423728, 16, 1'b1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule